// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block decides where a 32-bit core with 4-byte instructions fetches next. Each cycle in which `valid_i` is high, it takes the current program counter, the instruction word, the two register operands named by that instruction and the current interrupt-enable value. One clock edge later it presents the registered next program counter, a write request for the link register, an updated interrupt-enable value, and trap requests for system call, debug break and illegal trap codes.

The unit handles six compare-and-branch forms, a PC-relative jump and call with a 26-bit word offset, a jump and call through a register, and the two register jumps that return from an exception or a debug break. Those two jumps put a saved copy back into the global interrupt enable. The trap opcode leaves the next program counter on the trapping instruction's own address, so that vectoring logic outside this block can take over. When `valid_i` is low, the program counter holds and every strobe reads zero.

Top module: `bru_nextpc`

## Requirements
- R1: While reset is asserted and after it is released, `npc_o` equals `RESET_PC` (default 0), and `link_we_o`, `ie_we_o`, `ie_o` and all three trap outputs are 0.
- R2: Any opcode (insn[31:26]) other than 0x11–0x15, 0x17, 0x2B, 0x30, 0x36, 0x38 and 0x3E gives `npc_o` = aligned PC + 4 on the cycle after `valid_i`, with no link write, no interrupt-enable write and no trap.
- R3: Opcodes 0x11 (equal), 0x17 (not equal), 0x12 (signed greater), 0x13 (signed greater-or-equal), 0x15 (unsigned greater) and 0x14 (unsigned greater-or-equal) compare `opa_i` against `opb_i`. When the condition holds, the target is aligned PC + (sign-extended insn[15:0] << 2). Otherwise it is aligned PC + 4.
- R4: Opcodes 0x38 (jump) and 0x3E (call) go to aligned PC + (sign-extended insn[25:0] << 2).
- R5: The call forms 0x36 and 0x3E raise `link_we_o` with `link_idx_o` = 29 and `link_data_o` = aligned PC + 4. No other opcode raises `link_we_o`.
- R6: Opcodes 0x30 (jump) and 0x36 (call) go to `opa_i` with its two low bits cleared.
- R7: Interrupt-enable bits are bit 0 global enable, bit 1 exception-saved copy and bit 2 break-saved copy. Opcode 0x30 with insn[25:21] = 30 copies bit 1 into bit 0, and with insn[25:21] = 31 copies bit 2 into bit 0. Both raise `ie_we_o` and keep bits 1 and 2. Any other register in the 0x30 jump leaves `ie_o` equal to `ie_i` with `ie_we_o` low.
- R8: Opcode 0x2B raises `trap_scall_o` when insn[4:0] = 7, `trap_brk_o` when it is 2, and `trap_ill_o` for any other value. Exactly one of the three is set. Both `npc_o` and `trap_pc_o` equal the trapping instruction's aligned address.
- R9: Bits [1:0] of `pc_i` have no effect on any result.
- R10: A cycle with `valid_i` low leaves `npc_o` unchanged and clears `link_we_o`, `ie_we_o` and all trap outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction present this cycle |
| pc_i | input | 32 | Address of the instruction |
| insn_i | input | 32 | Instruction word |
| opa_i | input | 32 | Value of the register named by insn[25:21] |
| opb_i | input | 32 | Value of the register named by insn[20:16] |
| ie_i | input | 3 | Current interrupt-enable value |
| npc_o | output | 32 | Registered next program counter |
| link_we_o | output | 1 | Link register write strobe |
| link_idx_o | output | 5 | Link register index (29) |
| link_data_o | output | 32 | Return address for the link write |
| ie_we_o | output | 1 | Interrupt-enable write strobe |
| ie_o | output | 3 | Updated interrupt-enable value |
| trap_scall_o | output | 1 | System-call trap request |
| trap_brk_o | output | 1 | Debug-break trap request |
| trap_ill_o | output | 1 | Illegal trap-code request |
| trap_pc_o | output | 32 | Address saved for the trap |

## Verification
Every result is registered once, so a fault in the decoder, the comparator or the target adder shows up on `npc_o` at the edge after the instruction. It appears either as a target off by the offset or as a branch taken the wrong way. The signed and unsigned compares are exercised with operands whose sign bits differ, so that mixing up the two kinds changes the target. A bad interrupt-enable restore shows only in bit 0 of `ie_o` on that same cycle. For that reason, each restore form is run with both values of the saved bit, and the other bits are set so that a wrong source is visible. A strobe that fails to clear is caught in the first idle cycle after a trap.

// File: rtl/bru_pkg.sv
package bru_pkg;

  localparam int ILEN  = 32;
  localparam int OPW   = 6;
  localparam int REGW  = 5;
  localparam int IMMW  = 26;

  localparam logic [OPW-1:0] OP_BEQ   = 6'h11;
  localparam logic [OPW-1:0] OP_BGTS  = 6'h12;
  localparam logic [OPW-1:0] OP_BGES  = 6'h13;
  localparam logic [OPW-1:0] OP_BGEU  = 6'h14;
  localparam logic [OPW-1:0] OP_BGTU  = 6'h15;
  localparam logic [OPW-1:0] OP_BNEQ  = 6'h17;
  localparam logic [OPW-1:0] OP_TRAP  = 6'h2B;
  localparam logic [OPW-1:0] OP_JREG  = 6'h30;
  localparam logic [OPW-1:0] OP_CREG  = 6'h36;
  localparam logic [OPW-1:0] OP_JREL  = 6'h38;
  localparam logic [OPW-1:0] OP_CREL  = 6'h3E;

  localparam logic [REGW-1:0] REG_LINK = 5'd29;
  localparam logic [REGW-1:0] REG_EXC  = 5'd30;
  localparam logic [REGW-1:0] REG_DBG  = 5'd31;

  localparam logic [4:0] TRAP_SYS = 5'd7;
  localparam logic [4:0] TRAP_DBG = 5'd2;

  // interrupt-enable bit positions
  localparam int IE_W   = 3;
  localparam int IE_GIE = 0;
  localparam int IE_EXC = 1;
  localparam int IE_DBG = 2;

  typedef enum logic [2:0] {
    FL_SEQ, FL_COND, FL_REL, FL_REG, FL_TRAP
  } flow_e;

  typedef enum logic [2:0] {
    CC_EQ, CC_NE, CC_GT, CC_GE, CC_GTU, CC_GEU
  } cond_e;

  typedef enum logic [1:0] {
    RS_NONE, RS_EXC, RS_DBG
  } restore_e;

  typedef struct packed {
    logic sys;
    logic dbg;
    logic ill;
  } trap_t;

  typedef struct packed {
    flow_e    flow;
    cond_e    cond;
    logic     call;
    restore_e restore;
    trap_t    trap;
  } dec_t;

endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
(
  input  logic [OPW-1:0]  op_i,
  input  logic [REGW-1:0] ra_i,
  input  logic [4:0]      code_i,
  output dec_t            dec_o
);

  always_comb begin
    dec_o = '{flow: FL_SEQ, cond: CC_EQ, call: 1'b0,
              restore: RS_NONE, trap: '0};
    unique case (op_i)
      OP_BEQ:  begin dec_o.flow = FL_COND; dec_o.cond = CC_EQ;  end
      OP_BNEQ: begin dec_o.flow = FL_COND; dec_o.cond = CC_NE;  end
      OP_BGTS: begin dec_o.flow = FL_COND; dec_o.cond = CC_GT;  end
      OP_BGES: begin dec_o.flow = FL_COND; dec_o.cond = CC_GE;  end
      OP_BGTU: begin dec_o.flow = FL_COND; dec_o.cond = CC_GTU; end
      OP_BGEU: begin dec_o.flow = FL_COND; dec_o.cond = CC_GEU; end
      OP_JREL: dec_o.flow = FL_REL;
      OP_CREL: begin dec_o.flow = FL_REL; dec_o.call = 1'b1; end
      OP_CREG: begin dec_o.flow = FL_REG; dec_o.call = 1'b1; end
      OP_JREG: begin
        dec_o.flow = FL_REG;
        if (ra_i == REG_EXC)      dec_o.restore = RS_EXC;
        else if (ra_i == REG_DBG) dec_o.restore = RS_DBG;
      end
      OP_TRAP: begin
        dec_o.flow = FL_TRAP;
        if (code_i == TRAP_SYS)      dec_o.trap.sys = 1'b1;
        else if (code_i == TRAP_DBG) dec_o.trap.dbg = 1'b1;
        else                         dec_o.trap.ill = 1'b1;
      end
      default: dec_o.flow = FL_SEQ;
    endcase
  end

endmodule

// File: rtl/bru_cmp.sv
module bru_cmp
  import bru_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter bit SHARED_SUB = 1'b1
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  cond_e           cond_i,
  output logic            taken_o
);

  logic eq, ltu, lts;

  generate
    if (SHARED_SUB) begin : g_sub
      // one subtractor yields equality, unsigned and signed order
      logic [XLEN:0] diff;
      assign diff = {1'b0, a_i} - {1'b0, b_i};
      assign eq   = (diff[XLEN-1:0] == '0);
      assign ltu  = diff[XLEN];
      assign lts  = (a_i[XLEN-1] != b_i[XLEN-1]) ? a_i[XLEN-1] : ltu;
    end else begin : g_cmp
      assign eq  = (a_i == b_i);
      assign ltu = (a_i < b_i);
      assign lts = ($signed(a_i) < $signed(b_i));
    end
  endgenerate

  always_comb begin
    unique case (cond_i)
      CC_EQ:   taken_o = eq;
      CC_NE:   taken_o = !eq;
      CC_GT:   taken_o = !lts && !eq;
      CC_GE:   taken_o = !lts;
      CC_GTU:  taken_o = !ltu && !eq;
      CC_GEU:  taken_o = !ltu;
      default: taken_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/bru_target.sv
module bru_target
  import bru_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc_al_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic [XLEN-1:0] opa_i,
  input  flow_e           flow_i,
  input  logic            taken_i,
  output logic [XLEN-1:0] npc_o
);

  localparam int PAD16 = XLEN - 18;
  localparam int PAD26 = XLEN - 28;
  localparam logic [XLEN-1:0] STEP  = XLEN'(4);
  localparam logic [XLEN-1:0] AMASK = {{(XLEN-2){1'b1}}, 2'b00};

  logic [XLEN-1:0] rel16, rel26, offset, sum;

  assign rel16 = {{PAD16{imm_i[15]}}, imm_i[15:0], 2'b00};
  assign rel26 = {{PAD26{imm_i[IMMW-1]}}, imm_i, 2'b00};

  // single adder: only the offset operand is selected
  always_comb begin
    unique case (flow_i)
      FL_COND: offset = taken_i ? rel16 : STEP;
      FL_REL:  offset = rel26;
      FL_TRAP: offset = '0;
      default: offset = STEP;
    endcase
  end

  assign sum   = pc_al_i + offset;
  assign npc_o = (flow_i == FL_REG) ? (opa_i & AMASK) : sum;

endmodule

// File: rtl/bru_ie.sv
module bru_ie
  import bru_pkg::*;
(
  input  logic [IE_W-1:0] ie_i,
  input  restore_e        sel_i,
  output logic [IE_W-1:0] ie_o,
  output logic            we_o
);

  logic src_bit;

  assign src_bit = (sel_i == RS_DBG) ? ie_i[IE_DBG] : ie_i[IE_EXC];
  assign we_o    = (sel_i != RS_NONE);

  generate
    for (genvar k = 0; k < IE_W; k++) begin : g_bit
      if (k == IE_GIE) begin : g_gie
        assign ie_o[k] = we_o ? src_bit : ie_i[k];
      end else begin : g_keep
        assign ie_o[k] = ie_i[k];
      end
    end
  endgenerate

endmodule

// File: rtl/bru_nextpc.sv
module bru_nextpc
  import bru_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] RESET_PC   = '0,
  parameter bit              SHARED_SUB = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [ILEN-1:0] insn_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  input  logic [IE_W-1:0] ie_i,
  output logic [XLEN-1:0] npc_o,
  output logic            link_we_o,
  output logic [REGW-1:0] link_idx_o,
  output logic [XLEN-1:0] link_data_o,
  output logic            ie_we_o,
  output logic [IE_W-1:0] ie_o,
  output logic            trap_scall_o,
  output logic            trap_brk_o,
  output logic            trap_ill_o,
  output logic [XLEN-1:0] trap_pc_o
);

  localparam logic [XLEN-1:0] AMASK = {{(XLEN-2){1'b1}}, 2'b00};
  localparam logic [XLEN-1:0] STEP  = XLEN'(4);

  logic [XLEN-1:0] pc_al;
  dec_t            dec;
  logic            taken;
  logic [XLEN-1:0] tgt;
  logic [IE_W-1:0] ie_new;
  logic            ie_wr;

  assign pc_al = pc_i & AMASK;

  bru_decode u_dec (
    .op_i   (insn_i[31:26]),
    .ra_i   (insn_i[25:21]),
    .code_i (insn_i[4:0]),
    .dec_o  (dec)
  );

  bru_cmp #(.XLEN(XLEN), .SHARED_SUB(SHARED_SUB)) u_cmp (
    .a_i     (opa_i),
    .b_i     (opb_i),
    .cond_i  (dec.cond),
    .taken_o (taken)
  );

  bru_target #(.XLEN(XLEN)) u_tgt (
    .pc_al_i (pc_al),
    .imm_i   (insn_i[IMMW-1:0]),
    .opa_i   (opa_i),
    .flow_i  (dec.flow),
    .taken_i (taken),
    .npc_o   (tgt)
  );

  bru_ie u_ie (
    .ie_i  (ie_i),
    .sel_i (dec.restore),
    .ie_o  (ie_new),
    .we_o  (ie_wr)
  );

  // next-state
  logic [XLEN-1:0] npc_q, npc_d;
  logic            lwe_q, lwe_d;
  logic [XLEN-1:0] ldata_q, ldata_d;
  logic            iewe_q, iewe_d;
  logic [IE_W-1:0] ie_q, ie_d;
  trap_t           trap_q, trap_d;
  logic [XLEN-1:0] tpc_q, tpc_d;

  always_comb begin
    npc_d   = valid_i ? tgt : npc_q;
    lwe_d   = valid_i & dec.call;
    ldata_d = (valid_i & dec.call) ? (pc_al + STEP) : ldata_q;
    iewe_d  = valid_i & ie_wr;
    ie_d    = valid_i ? ie_new : ie_q;
    trap_d  = valid_i ? dec.trap : '0;
    tpc_d   = (valid_i && dec.flow == FL_TRAP) ? pc_al : tpc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      npc_q   <= RESET_PC;
      lwe_q   <= 1'b0;
      ldata_q <= '0;
      iewe_q  <= 1'b0;
      ie_q    <= '0;
      trap_q  <= '0;
      tpc_q   <= '0;
    end else begin
      npc_q   <= npc_d;
      lwe_q   <= lwe_d;
      ldata_q <= ldata_d;
      iewe_q  <= iewe_d;
      ie_q    <= ie_d;
      trap_q  <= trap_d;
      tpc_q   <= tpc_d;
    end
  end

  assign npc_o        = npc_q;
  assign link_we_o    = lwe_q;
  assign link_idx_o   = REG_LINK;
  assign link_data_o  = ldata_q;
  assign ie_we_o      = iewe_q;
  assign ie_o         = ie_q;
  assign trap_scall_o = trap_q.sys;
  assign trap_brk_o   = trap_q.dbg;
  assign trap_ill_o   = trap_q.ill;
  assign trap_pc_o    = tpc_q;

  // ---------------------------------------------------------------
  // assertions: opcode classes recomputed from the raw port
  logic [OPW-1:0] a_op;
  logic           a_plain;
  assign a_op    = insn_i[31:26];
  assign a_plain = !(a_op == 6'h11 || a_op == 6'h12 || a_op == 6'h13 ||
                     a_op == 6'h14 || a_op == 6'h15 || a_op == 6'h17 ||
                     a_op == 6'h2B || a_op == 6'h30 || a_op == 6'h36 ||
                     a_op == 6'h38 || a_op == 6'h3E);

  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && a_plain |=> npc_o == $past(pc_i & AMASK) + STEP
                           && !link_we_o && !ie_we_o);

  p_call_link_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && (a_op == 6'h36 || a_op == 6'h3E)
    |=> link_we_o && link_idx_o == 5'd29
        && link_data_o == $past(pc_i & AMASK) + STEP);

  p_reg_jump_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && (a_op == 6'h30 || a_op == 6'h36)
    |=> npc_o[XLEN-1:2] == $past(opa_i[XLEN-1:2]) && npc_o[1:0] == 2'b00);

  p_exc_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && a_op == 6'h30 && insn_i[25:21] == 5'd30
    |=> ie_we_o && ie_o[0] == $past(ie_i[1]) && ie_o[2:1] == $past(ie_i[2:1]));

  p_trap_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && a_op == 6'h2B
    |=> $countones({trap_scall_o, trap_brk_o, trap_ill_o}) == 1
        && npc_o == trap_pc_o && trap_pc_o == $past(pc_i & AMASK));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(npc_o) && !link_we_o && !ie_we_o
                 && !trap_scall_o && !trap_brk_o && !trap_ill_o);

endmodule

// File: tb/tb_bru_nextpc.sv
module tb_bru_nextpc;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 25;

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] insn;
    logic [31:0] a;
    logic [31:0] b;
    logic [2:0]  ie;
    logic [31:0] npc;
    logic        lwe;
    logic [31:0] ldata;
    logic        iewe;
    logic [2:0]  eie;
    logic [2:0]  exc;   // {ill, brk, scall}
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VT [NV] = '{
    // R2 plain opcode
    '{32'h1000, 32'h34000005, 32'h0, 32'h0, 3'b000, 32'h1004, 1'b0, 32'h0, 1'b0, 3'b000, 3'b000, 8'd2},
    // R3 equal taken / not taken
    '{32'h1000, 32'h44000004, 32'h5, 32'h5, 3'b000, 32'h1010, 1'b0, 32'h0, 1'b0, 3'b000, 3'b000, 8'd3},
    '{32'h1000, 32'h44000004, 32'h5, 32'h6, 3'b000, 32'h1004, 1'b0, 32'h0, 1'b0, 3'b000, 3'b000, 8'd3},
    // R3 not equal, negative offset
    '{32'h1000, 32'h5C00FFFC, 32'h5, 32'h6, 3'b000, 32'h0FF0, 1'b0, 32'h0, 1'b0, 3'b000, 3'b000, 8'd3},
    // R3 signed greater vs unsigned greater on same operands
    '{32'h1000, 32'h48000008, 32'h1, 32'hFFFFFFFF, 3'b000, 32'h1020, 1'b0, 32'h0, 1'b0, 3'b000, 3'b000, 8'd3},
    '{32'h1000, 32'h54000008, 32'h1, 32'hFFFFFFFF, 3'b000, 32'h1004, 1'b0, 32'h0, 1'b0, 3'b000, 3'b000, 8'd3},
    '{32'h1000, 32'h54000008, 32'hFFFFFFFF, 32'h1, 3'b000, 32'h1020, 1'b0, 32'h0, 1'b0, 3'b000, 3'b000, 8'd3},
    // R3 signed ge equal operands, unsigned ge vs signed ge
    '{32'h1000, 32'h4C000002, 32'h7, 32'h7, 3'b000, 32'h1008, 1'b0, 32'h0, 1'b0, 3'b000, 3'b000, 8'd3},
    '{32'h1000, 32'h50000003, 32'h80000000, 32'h1, 3'b000, 32'h100C, 1'b0, 32'h0, 1'b0, 3'b000, 3'b000, 8'd3},
    '{32'h1000, 32'h4C000003, 32'h80000000, 32'h1, 3'b000, 32'h1004, 1'b0, 32'h0, 1'b0, 3'b000, 3'b000, 8'd3},
    // R4 relative jump backwards
    '{32'h1000, 32'hE3FFFFFF, 32'h0, 32'h0, 3'b000, 32'h0FFC, 1'b0, 32'h0, 1'b0, 3'b000, 3'b000, 8'd4},
    // R5 relative call with link
    '{32'h1000, 32'hF8000100, 32'h0, 32'h0, 3'b000, 32'h1400, 1'b1, 32'h1004, 1'b0, 3'b000, 3'b000, 8'd5},
    // R5 R6 register call, low bits of target cleared
    '{32'h1000, 32'hD8600000, 32'h2002, 32'h0, 3'b000, 32'h2000, 1'b1, 32'h1004, 1'b0, 3'b000, 3'b000, 8'd5},
    // R6 register jump through r29: no enable change
    '{32'h1000, 32'hC3A00000, 32'h3000, 32'h0, 3'b110, 32'h3000, 1'b0, 32'h0, 1'b0, 3'b110, 3'b000, 8'd6},
    // R7 exception return
    '{32'h1000, 32'hC3C00000, 32'h4000, 32'h0, 3'b010, 32'h4000, 1'b0, 32'h0, 1'b1, 3'b011, 3'b000, 8'd7},
    '{32'h1000, 32'hC3C00000, 32'h4000, 32'h0, 3'b101, 32'h4000, 1'b0, 32'h0, 1'b1, 3'b100, 3'b000, 8'd7},
    // R7 break return
    '{32'h1000, 32'hC3E00000, 32'h5004, 32'h0, 3'b100, 32'h5004, 1'b0, 32'h0, 1'b1, 3'b101, 3'b000, 8'd7},
    '{32'h1000, 32'hC3E00000, 32'h5004, 32'h0, 3'b011, 32'h5004, 1'b0, 32'h0, 1'b1, 3'b010, 3'b000, 8'd7},
    // R8 trap codes
    '{32'h1000, 32'hAC000007, 32'h0, 32'h0, 3'b000, 32'h1000, 1'b0, 32'h0, 1'b0, 3'b000, 3'b001, 8'd8},
    '{32'h1000, 32'hAC000002, 32'h0, 32'h0, 3'b000, 32'h1000, 1'b0, 32'h0, 1'b0, 3'b000, 3'b010, 8'd8},
    '{32'h1000, 32'hAC000003, 32'h0, 32'h0, 3'b000, 32'h1000, 1'b0, 32'h0, 1'b0, 3'b000, 3'b100, 8'd8},
    // R9 misaligned PC bits ignored
    '{32'h1003, 32'h34000005, 32'h0, 32'h0, 3'b000, 32'h1004, 1'b0, 32'h0, 1'b0, 3'b000, 3'b000, 8'd9},
    '{32'h1002, 32'h44000004, 32'h5, 32'h5, 3'b000, 32'h1010, 1'b0, 32'h0, 1'b0, 3'b000, 3'b000, 8'd9},
    '{32'h2001, 32'hAC000007, 32'h0, 32'h0, 3'b000, 32'h2000, 1'b0, 32'h0, 1'b0, 3'b000, 3'b001, 8'd9},
    '{32'h1001, 32'hF8000100, 32'h0, 32'h0, 3'b000, 32'h1400, 1'b1, 32'h1004, 1'b0, 3'b000, 3'b000, 8'd9}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i;
  logic [31:0] pc_i, insn_i, opa_i, opb_i;
  logic [2:0]  ie_i;
  logic [31:0] npc_o, link_data_o, trap_pc_o;
  logic        link_we_o, ie_we_o, trap_scall_o, trap_brk_o, trap_ill_o;
  logic [4:0]  link_idx_o;
  logic [2:0]  ie_o;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bru_nextpc dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .pc_i(pc_i),
    .insn_i(insn_i), .opa_i(opa_i), .opb_i(opb_i), .ie_i(ie_i),
    .npc_o(npc_o), .link_we_o(link_we_o), .link_idx_o(link_idx_o),
    .link_data_o(link_data_o), .ie_we_o(ie_we_o), .ie_o(ie_o),
    .trap_scall_o(trap_scall_o), .trap_brk_o(trap_brk_o),
    .trap_ill_o(trap_ill_o), .trap_pc_o(trap_pc_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] pc,
                       input logic [31:0] insn, input logic [31:0] a,
                       input logic [31:0] b, input logic [2:0] ie);
    valid_i = v; pc_i = pc; insn_i = insn; opa_i = a; opb_i = b; ie_i = ie;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] exc_bits();
    return {29'b0, trap_ill_o, trap_brk_o, trap_scall_o};
  endfunction

  initial begin
    #(CLK_PERIOD * 5000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; valid_i = 1'b0; pc_i = '0; insn_i = '0;
    opa_i = '0; opb_i = '0; ie_i = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", "npc in reset", npc_o, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 after release
    chk("R1", "npc", npc_o, 32'h0);
    chk("R1", "link_we", {31'b0, link_we_o}, 32'h0);
    chk("R1", "ie_we", {31'b0, ie_we_o}, 32'h0);
    chk("R1", "ie", {29'b0, ie_o}, 32'h0);
    chk("R1", "traps", exc_bits(), 32'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string r;
      v = VT[i];
      r = $sformatf("R%0d", v.req);
      drive(1'b1, v.pc, v.insn, v.a, v.b, v.ie);
      chk(r, $sformatf("npc v%0d", i), npc_o, v.npc);
      chk(r, $sformatf("link_we v%0d", i), {31'b0, link_we_o}, {31'b0, v.lwe});
      if (v.lwe) begin
        chk(r, $sformatf("link_data v%0d", i), link_data_o, v.ldata);
        chk(r, $sformatf("link_idx v%0d", i), {27'b0, link_idx_o}, 32'd29);
      end
      chk(r, $sformatf("ie_we v%0d", i), {31'b0, ie_we_o}, {31'b0, v.iewe});
      chk(r, $sformatf("ie v%0d", i), {29'b0, ie_o}, {29'b0, v.eie});
      chk(r, $sformatf("traps v%0d", i), exc_bits(), {29'b0, v.exc});
      if (v.exc != 3'b000)
        chk(r, $sformatf("trap_pc v%0d", i), trap_pc_o, v.npc);
    end

    // R10: after a trap and an enable restore, an idle cycle with
    // flow-changing junk on the inputs holds npc and clears strobes
    drive(1'b1, 32'h7000, 32'hAC000007, 32'h0, 32'h0, 3'b010);
    drive(1'b0, 32'h9000, 32'hF8000100, 32'h8000, 32'h0, 3'b010);
    chk("R10", "npc hold", npc_o, 32'h7000);
    chk("R10", "link_we clear", {31'b0, link_we_o}, 32'h0);
    chk("R10", "traps clear", exc_bits(), 32'h0);
    drive(1'b1, 32'h7000, 32'hC3C00000, 32'h6000, 32'h0, 3'b010);
    drive(1'b0, 32'h9000, 32'hC3C00000, 32'h8000, 32'h0, 3'b000);
    chk("R10", "npc hold after return", npc_o, 32'h6000);
    chk("R10", "ie_we clear", {31'b0, ie_we_o}, 32'h0);
    chk("R10", "ie hold", {29'b0, ie_o}, 32'h3);

    // R1: reset mid-run returns to the reset state
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "npc after re-reset", npc_o, 32'h0);
    chk("R1", "ie after re-reset", {29'b0, ie_o}, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule